// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the internal clock sources of a clock generator and its output pins. It receives an internal CPU-domain clock, an internal PCI-domain clock, and the reference and USB clocks. It forwards them to two CPU outputs, five stoppable PCI outputs, one free-running PCI output, one reference output and one USB output. Three active-low power-management inputs control the forwarding. A CPU halt holds the CPU outputs low. A PCI halt holds the five stoppable PCI outputs low. A power-off request holds every output low and drops the enables for the oscillator and the PLLs.

Each control is resynchronized into every clock domain it affects. Two flops clocked on the falling edge of that domain's clock do the synchronizing. A further falling-edge flop holds the gate enable, and each output is the AND of its input clock and that enable. The enable therefore only changes while the clock is low, so an output never carries a shortened pulse. When power-off is released, every domain waits a configurable number of its own cycles before it lets pulses out. This wait stands in for PLL lock time.

Top module: `clk_stop_ctrl`

## Requirements
- R1: The three controls `cpu_halt_n`, `pci_halt_n` and `pwr_off_n` request their action at logic 0. With all three at 1, every clock output toggles, and `osc_en_o` and `pll_en_o` are 1.
- R2: While `cpu_halt_n` is 0, both bits of `cpu_clk_o` stay low. The PCI, free-running, reference and USB outputs keep toggling.
- R3: While `pci_halt_n` is 0, all five bits of `pci_clk_o` stay low. `pci_free_o` and `cpu_clk_o` keep toggling.
- R4: While `pwr_off_n` is 0, every clock output stays low, and so do `osc_en_o` and `pll_en_o`. This holds whatever the two halt inputs are.
- R5: A halt takes effect on the high phase that follows the third falling edge of the gated clock after the control changes. The two high phases before that pass unchanged.
- R6: Every high pulse on any output is one complete high phase of its input clock. No output is ever high while its input clock is low.
- R7: After a halt is released, the first output pulse starts on a rising edge of the input clock, three periods after the rising edge that precedes the release.
- R8: After `pwr_off_n` returns to 1, a domain's outputs stay low until its gate has counted LOCK_CYCLES cycles of its own clock after synchronization. The first CPU pulse rises (LOCK_CYCLES+3) CPU periods after the CPU rising edge that precedes the release.
- R9: While `rst_n` is 0, all clock outputs and both source enables are low.
- R10: The reference and USB outputs are affected by `pwr_off_n` only, never by either halt input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | Internal CPU-domain clock |
| clk_pci_i | input | 1 | Internal PCI-domain clock |
| clk_ref_i | input | 1 | Reference clock, free-running from the crystal |
| clk_usb_i | input | 1 | USB-rate clock |
| rst_n | input | 1 | Active-low reset, sampled in each domain |
| cpu_halt_n | input | 1 | Active-low CPU output stop request |
| pci_halt_n | input | 1 | Active-low stop request for the stoppable PCI outputs |
| pwr_off_n | input | 1 | Active-low power-off request |
| cpu_clk_o | output | N_CPU (2) | Gated CPU clock outputs |
| pci_clk_o | output | N_PCI (5) | Gated stoppable PCI clock outputs |
| pci_free_o | output | 1 | PCI clock output exempt from the PCI halt |
| ref_clk_o | output | 1 | Gated reference clock output |
| usb_clk_o | output | 1 | Gated USB clock output |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |

## Verification
A halt reaches the pins on the high phase after the third falling edge of the gated clock. A release shows its first rising edge three input periods after the rising edge that precedes the control change. After power-off is released, the first pulse arrives LOCK_CYCLES periods later than that. The latency checks drive each control 1 ns after a rising edge. They then count rising edges over windows that end halfway between edges, so each check knows exactly how many pulses must have passed. The steady-state checks wait until every domain has settled, including the lock wait. They then compare which outputs toggled over a 300 ns window, while a width monitor times every high pulse against half its input period.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the clock stop controller.
// Assumes callers pass a positive count to the width helper.
package ckg_pkg;

    // Default depth of every control synchronizer.
    localparam int unsigned CKG_SYNC_DEPTH = 2;

    // Counter width able to hold the value n (at least one bit).
    function automatic int unsigned ckg_cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ckg_sync.sv
`timescale 1ns/1ps
// Module: ckg_sync
// Brings an asynchronous level into one clock domain through a chain of
// flops clocked on the falling edge. Reset forces the chain to zero, which
// reads as "request active" for the active-low controls fed through it.
// Assumes rst_n is held low for at least STAGES falling edges.
module ckg_sync #(
    parameter int unsigned STAGES = ckg_pkg::CKG_SYNC_DEPTH
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the chain on every falling edge.
    always_ff @(negedge clk_i) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ckg_domain_gate.sv
`timescale 1ns/1ps
// Module: ckg_domain_gate
// Gates N_OUT copies of one clock. A halt request and a power-off request
// are each synchronized on the falling edge. After power-off clears, a
// counter waits LOCK_CYCLES falling edges before the gate may open. The
// enable flops change only on a falling edge, i.e. while clk_i is low, so
// each output (clk_i AND enable) carries whole high phases only.
// Assumes clk_i keeps toggling whenever a state change is expected.
module ckg_domain_gate #(
    parameter int unsigned N_OUT       = 1,
    parameter int unsigned LOCK_CYCLES = 16,
    parameter int unsigned SYNC_STAGES = ckg_pkg::CKG_SYNC_DEPTH
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             halt_n_i,
    input  logic             pwr_n_i,
    output logic [N_OUT-1:0] clk_o
);
    localparam int unsigned CW = ckg_pkg::ckg_cnt_width(LOCK_CYCLES);
    localparam logic [CW-1:0] LOCK_MAX = CW'(LOCK_CYCLES);

    logic          halt_n_s;
    logic          pwr_n_s;
    logic [CW-1:0] lock_cnt_q;
    logic          locked;
    logic          open_d;

    ckg_sync #(.STAGES(SYNC_STAGES)) u_halt_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (halt_n_i),
        .q_o   (halt_n_s)
    );

    ckg_sync #(.STAGES(SYNC_STAGES)) u_pwr_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (pwr_n_i),
        .q_o   (pwr_n_s)
    );

    // Count cycles since power returned; saturate at the lock limit.
    always_ff @(negedge clk_i) begin
        if (!rst_n || !pwr_n_s) begin
            lock_cnt_q <= '0;
        end else if (lock_cnt_q != LOCK_MAX) begin
            lock_cnt_q <= lock_cnt_q + 1'b1;
        end
    end

    assign locked = (lock_cnt_q == LOCK_MAX);
    assign open_d = pwr_n_s && locked && halt_n_s;

    // One enable flop per output keeps the fanout of each gate at one.
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        logic en_q;

        // Update the enable only while the clock is low.
        always_ff @(negedge clk_i) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else begin
                en_q <= open_d;
            end
        end

        assign clk_o[g] = clk_i & en_q;
    end
endmodule

// File: rtl/ckg_src_ctrl.sv
`timescale 1ns/1ps
// Module: ckg_src_ctrl
// Produces the oscillator and PLL enables from the power-off request,
// synchronized into the reference domain. Assumes the reference input
// clock runs from the crystal and keeps toggling while power-off is active.
module ckg_src_ctrl #(
    parameter int unsigned SYNC_STAGES = ckg_pkg::CKG_SYNC_DEPTH
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic pwr_n_i,
    output logic osc_en_o,
    output logic pll_en_o
);
    logic pwr_n_s;

    ckg_sync #(.STAGES(SYNC_STAGES)) u_pwr_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (pwr_n_i),
        .q_o   (pwr_n_s)
    );

    // Both sources follow the synchronized power request.
    assign osc_en_o = pwr_n_s;
    assign pll_en_o = pwr_n_s;
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
// Module: clk_stop_ctrl (top)
// Gates the CPU, PCI, free-running PCI, reference and USB outputs under
// three active-low controls. Each output group has its own gate with its
// own synchronizers. Groups exempt from a halt tie that gate's halt input
// high. Power-off reaches every gate and the source enables.
// Assumes all input clocks keep toggling, including during power-off.
module clk_stop_ctrl #(
    parameter int unsigned N_CPU       = 2,
    parameter int unsigned N_PCI       = 5,
    parameter int unsigned LOCK_CYCLES = 16,
    parameter int unsigned SYNC_STAGES = ckg_pkg::CKG_SYNC_DEPTH
) (
    input  logic             clk_cpu_i,
    input  logic             clk_pci_i,
    input  logic             clk_ref_i,
    input  logic             clk_usb_i,
    input  logic             rst_n,
    input  logic             cpu_halt_n,
    input  logic             pci_halt_n,
    input  logic             pwr_off_n,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o,
    output logic             ref_clk_o,
    output logic             usb_clk_o,
    output logic             osc_en_o,
    output logic             pll_en_o
);
    // CPU group: obeys the CPU halt.
    ckg_domain_gate #(
        .N_OUT(N_CPU), .LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
    ) u_cpu (
        .clk_i    (clk_cpu_i),
        .rst_n    (rst_n),
        .halt_n_i (cpu_halt_n),
        .pwr_n_i  (pwr_off_n),
        .clk_o    (cpu_clk_o)
    );

    // Stoppable PCI group: obeys the PCI halt.
    ckg_domain_gate #(
        .N_OUT(N_PCI), .LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
    ) u_pci (
        .clk_i    (clk_pci_i),
        .rst_n    (rst_n),
        .halt_n_i (pci_halt_n),
        .pwr_n_i  (pwr_off_n),
        .clk_o    (pci_clk_o)
    );

    // Free-running PCI output: exempt from the PCI halt.
    ckg_domain_gate #(
        .N_OUT(1), .LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
    ) u_pci_free (
        .clk_i    (clk_pci_i),
        .rst_n    (rst_n),
        .halt_n_i (1'b1),
        .pwr_n_i  (pwr_off_n),
        .clk_o    (pci_free_o)
    );

    // Reference output: power-off only.
    ckg_domain_gate #(
        .N_OUT(1), .LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
    ) u_ref (
        .clk_i    (clk_ref_i),
        .rst_n    (rst_n),
        .halt_n_i (1'b1),
        .pwr_n_i  (pwr_off_n),
        .clk_o    (ref_clk_o)
    );

    // USB output: power-off only.
    ckg_domain_gate #(
        .N_OUT(1), .LOCK_CYCLES(LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
    ) u_usb (
        .clk_i    (clk_usb_i),
        .rst_n    (rst_n),
        .halt_n_i (1'b1),
        .pwr_n_i  (pwr_off_n),
        .clk_o    (usb_clk_o)
    );

    // Oscillator and PLL enables, in the reference domain.
    ckg_src_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk_i    (clk_ref_i),
        .rst_n    (rst_n),
        .pwr_n_i  (pwr_off_n),
        .osc_en_o (osc_en_o),
        .pll_en_o (pll_en_o)
    );
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
// Module: clk_stop_ctrl_chk
// Property checker bound to clk_stop_ctrl. Outputs sampled at a falling
// edge show the enable that held during the high phase just ended. Outputs
// sampled at a rising edge show the level during the low phase.
module clk_stop_ctrl_chk #(
    parameter int unsigned N_CPU = 2,
    parameter int unsigned N_PCI = 5
) (
    input logic             clk_cpu_i,
    input logic             clk_pci_i,
    input logic             clk_ref_i,
    input logic             rst_n,
    input logic             cpu_halt_n,
    input logic             pci_halt_n,
    input logic             pwr_off_n,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_PCI-1:0] pci_clk_o,
    input logic             pci_free_o,
    input logic             osc_en_o,
    input logic             pll_en_o
);
    // R2: a CPU halt held for four falling edges silences the CPU outputs.
    p_cpu_held_r2: assert property (@(negedge clk_cpu_i) disable iff (!rst_n)
        (!cpu_halt_n && !$past(cpu_halt_n) && !$past(cpu_halt_n, 2) && !$past(cpu_halt_n, 3))
        |-> (cpu_clk_o == '0));

    // R3: a PCI halt held for four falling edges silences the stoppable PCI outputs.
    p_pci_held_r3: assert property (@(negedge clk_pci_i) disable iff (!rst_n)
        (!pci_halt_n && !$past(pci_halt_n) && !$past(pci_halt_n, 2) && !$past(pci_halt_n, 3))
        |-> (pci_clk_o == '0));

    // R4: a held power-off silences the CPU outputs.
    p_pwr_cpu_r4: assert property (@(negedge clk_cpu_i) disable iff (!rst_n)
        (!pwr_off_n && !$past(pwr_off_n) && !$past(pwr_off_n, 2) && !$past(pwr_off_n, 3))
        |-> (cpu_clk_o == '0));

    // R4: a held power-off silences the free-running PCI output as well.
    p_pwr_free_r4: assert property (@(negedge clk_pci_i) disable iff (!rst_n)
        (!pwr_off_n && !$past(pwr_off_n) && !$past(pwr_off_n, 2) && !$past(pwr_off_n, 3))
        |-> !pci_free_o);

    // R4: a held power-off drops both source enables.
    p_pwr_src_r4: assert property (@(negedge clk_ref_i) disable iff (!rst_n)
        (!pwr_off_n && !$past(pwr_off_n) && !$past(pwr_off_n, 2) && !$past(pwr_off_n, 3))
        |-> (!osc_en_o && !pll_en_o));

    // R6: no CPU output is high while the CPU clock is low.
    p_cpu_low_phase_r6: assert property (@(posedge clk_cpu_i) disable iff (!rst_n)
        cpu_clk_o == '0);

    // R6: no PCI output is high while the PCI clock is low.
    p_pci_low_phase_r6: assert property (@(posedge clk_pci_i) disable iff (!rst_n)
        (pci_clk_o == '0) && !pci_free_o);

    // R9: reset keeps the CPU outputs low through the next high phase.
    p_reset_quiet_r9: assert property (@(negedge clk_cpu_i)
        !rst_n |=> (cpu_clk_o == '0));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (.*);

// File: tb/sim_clk_stop_ctrl.sv
`timescale 1ns/1ps
// Bench for clk_stop_ctrl. A driver applies controls and queues the
// expected set of toggling outputs. A monitor pops each item, watches a
// window of edges and compares. Latency checks are made directly by the
// driver against times derived from the requirements.
module sim_clk_stop_ctrl;
    localparam int      LOCK = 16;
    localparam realtime TC = 5.0, TP = 10.0, TR = 14.0, TU = 8.0;

    logic clk_cpu_i = 0, clk_pci_i = 0, clk_ref_i = 0, clk_usb_i = 0;
    logic rst_n = 0, cpu_halt_n = 1, pci_halt_n = 1, pwr_off_n = 1;
    logic [1:0] cpu_clk_o;
    logic [4:0] pci_clk_o;
    logic pci_free_o, ref_clk_o, usb_clk_o, osc_en_o, pll_en_o;

    always #(TC/2) clk_cpu_i = ~clk_cpu_i;
    always #(TP/2) clk_pci_i = ~clk_pci_i;
    always #(TR/2) clk_ref_i = ~clk_ref_i;
    always #(TU/2) clk_usb_i = ~clk_usb_i;

    clk_stop_ctrl #(.N_CPU(2), .N_PCI(5), .LOCK_CYCLES(LOCK)) u0 (.*);

    // Output bits: 0-1 CPU, 2-6 PCI, 7 free PCI, 8 reference, 9 USB.
    logic [9:0] obs;
    assign obs = {usb_clk_o, ref_clk_o, pci_free_o, pci_clk_o, cpu_clk_o};

    int      checks = 0, fails = 0, runts = 0;
    int      rc [10];
    realtime trise [10];
    logic [9:0] prev = '0;

    function automatic realtime half_period(input int i);
        if (i < 2) return TC/2;
        if (i < 8) return TP/2;
        if (i == 8) return TR/2;
        return TU/2;
    endfunction

    // Edge counter and pulse-width monitor (R6).
    initial for (int i = 0; i < 10; i++) begin rc[i] = 0; trise[i] = 0.0; end
    always @(obs) begin
        for (int i = 0; i < 10; i++) begin
            if (obs[i] === 1'b1 && prev[i] !== 1'b1) begin
                rc[i] = rc[i] + 1;
                trise[i] = $realtime;
            end else if (obs[i] !== 1'b1 && prev[i] === 1'b1) begin
                if ($realtime - trise[i] < half_period(i) - 0.01) runts = runts + 1;
            end
        end
        prev = obs;
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard: bits 0-9 as obs, bit 10 oscillator enable, bit 11 PLL enable.
    typedef struct { string tag; logic [11:0] exp; } sb_item_t;
    sb_item_t sbq[$];
    bit mon_busy = 0;

    initial begin : monitor
        forever begin
            sb_item_t it;
            int snap [10];
            logic [11:0] act;
            wait (sbq.size() > 0);
            mon_busy = 1;
            it = sbq.pop_front();
            for (int i = 0; i < 10; i++) snap[i] = rc[i];
            #300;
            for (int i = 0; i < 10; i++) act[i] = (rc[i] != snap[i]);
            act[10] = osc_en_o;
            act[11] = pll_en_o;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%03h expected=%03h", it.tag, act, it.exp);
            end
            mon_busy = 0;
        end
    end

    task automatic push(input string tag, input logic [11:0] exp);
        sb_item_t it;
        it.tag = tag;
        it.exp = exp;
        sbq.push_back(it);
        #1;
        wait (!mon_busy);
    endtask

    task automatic apply(input logic ch, input logic ph, input logic pw, input realtime settle);
        cpu_halt_n = ch;
        pci_halt_n = ph;
        pwr_off_n  = pw;
        #(settle);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        #500us;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin : driver
        realtime t0;
        int n0;
        // R9: reset state.
        #100;
        chk("R9 outputs low in reset", obs === 10'b0, int'(obs), 0);
        chk("R9 source enables low in reset", {osc_en_o, pll_en_o} === 2'b00,
            int'({osc_en_o, pll_en_o}), 0);
        rst_n = 1;
        #600;
        push("R1 all released, all run", 12'hFFF);
        apply(0, 1, 1, 200);
        push("R2/R10 CPU halt", 12'hFFC);
        apply(1, 0, 1, 200);
        push("R3/R10 PCI halt, free runs", 12'hF83);
        apply(0, 0, 1, 200);
        push("R2/R3 both halts", 12'hF80);
        apply(1, 1, 0, 200);
        push("R4 power-off", 12'h000);
        apply(0, 0, 0, 200);
        push("R4 power-off with halts", 12'h000);
        apply(1, 1, 1, 600);
        push("R8 all run after power return", 12'hFFF);

        // R5: CPU halt latency, driven 1 ns after a rising edge.
        @(posedge clk_cpu_i); #1;
        n0 = rc[0];
        cpu_halt_n = 0;
        #20;
        chk("R5 CPU pulses after halt", rc[0] - n0 == 2, rc[0] - n0, 2);
        #100;
        // R7: CPU release, first rise three periods after the prior edge.
        @(posedge clk_cpu_i); #1;
        t0 = $realtime; n0 = rc[0];
        cpu_halt_n = 1;
        #15;
        chk("R7 CPU one pulse after release", rc[0] - n0 == 1, rc[0] - n0, 1);
        chk("R7 CPU first rise time", int'(trise[0] - t0) == 14, int'(trise[0] - t0), 14);

        // R5: PCI halt latency; the free output keeps toggling.
        @(posedge clk_pci_i); #1;
        n0 = rc[2];
        pci_halt_n = 0;
        #39;
        chk("R5 PCI pulses after halt", rc[2] - n0 == 2, rc[2] - n0, 2);
        #200;
        // R7: PCI release.
        @(posedge clk_pci_i); #1;
        t0 = $realtime; n0 = rc[2];
        pci_halt_n = 1;
        #30;
        chk("R7 PCI one pulse after release", rc[2] - n0 == 1, rc[2] - n0, 1);
        chk("R7 PCI first rise time", int'(trise[2] - t0) == 29, int'(trise[2] - t0), 29);

        // R8: lock wait after power-off release.
        pwr_off_n = 0;
        #300;
        @(posedge clk_cpu_i); #1;
        t0 = $realtime; n0 = rc[0];
        pwr_off_n = 1;
        #((LOCK + 3) * TC - 2);
        chk("R8 CPU still low before lock", rc[0] == n0, rc[0] - n0, 0);
        #2;
        chk("R8 CPU first pulse after lock", rc[0] - n0 == 1, rc[0] - n0, 1);
        chk("R8 CPU first rise time", int'(trise[0] - t0) == (LOCK + 3) * 5 - 1,
            int'(trise[0] - t0), (LOCK + 3) * 5 - 1);
        chk("R8 oscillator enable up", osc_en_o === 1'b1, int'(osc_en_o), 1);

        #100;
        chk("R6 no short pulses", runts == 0, runts, 0);
        finish_run();
    end
endmodule